// File: doc/BRIEF.md
# Interrupt priority register file

This block holds the priority settings of an interrupt controller. Each interrupt source from 1 to `NUM_SOURCES` has a priority register, and each target context has a threshold register. Software reaches both through a simple register bus that has a valid strobe, a write flag, an address, write data, registered read data and an error flag. A word of source pending bits can be read back through the same bus.

Each context has a request output. It is high while at least one pending source has a priority strictly above that context's threshold. Priority and threshold writes are legalized. When `MAX_PRIO+1` is a power of two, any value is accepted and the unsupported upper bits are dropped. Otherwise a value above `MAX_PRIO` is discarded and the old setting stays. Claim, completion, enables and selection of the winning source belong to other blocks.

Top module: `prio_regfile`

## Requirements
- R1: The priority of source n (1..NUM_SOURCES) is at byte address PRIORITY_BASE + 4*(n-1). It reads back as the stored value with zeros above the priority width, and no other source's register is affected by the write.
- R2: When MAX_PRIO+1 is a power of two, every priority write is accepted and stores the written value modulo MAX_PRIO+1.
- R3: When MAX_PRIO+1 is not a power of two, a priority write above MAX_PRIO leaves the old value in place, and a write of at most MAX_PRIO stores the value unchanged.
- R4: The threshold of context c sits at CONTEXT_BASE + c*CONTEXT_STRIDE. It follows the same legalization as R2/R3, and a write to one context leaves the other contexts unchanged.
- R5: A read of word k at PENDING_BASE + 4*k returns pending bits 32k..32k+31, with bit j holding source 32k+j. A write there changes no register and raises bus_err in the following cycle.
- R6: irq[c] is high when some source n>=1 has pending[n]=1 and priority[n] > threshold[c]. pending[0] is ignored. An accepted write takes effect on irq in the cycle after its clock edge.
- R7: A source with priority 0 never raises any irq.
- R8: Reads of unmapped addresses, including non-zero offsets inside a context window, return 0. Writes there change nothing. bus_err is 0 for every access other than a write to the pending region.
- R9: A synchronous active-high reset clears all priorities and thresholds, bus_rdata and bus_err.
- R10: Read data appears in the cycle after the read request. In any cycle that does not follow a read, bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error, set for writes to the pending region |
| pending | input | NUM_SOURCES+1 | Pending bit per source; bit 0 is unused |
| irq | output | NUM_CONTEXTS | Request per context |

## Verification
Read data and the error flag come from registers. Each is due one cycle after the access is presented. The bench drives every access on a falling edge and samples both outputs on the next falling edge, after the capturing rising edge. The request outputs are combinational from the stored settings and the pending input. They are sampled on the falling edge that ends a write, which is the first point at which the new setting is visible, and a short delay after any change to the pending bits. Two instances, one with a wrapping priority range and one with a rejecting range, receive identical traffic so that both legalization rules are checked against the same stimulus.

// File: rtl/prio_regfile.sv
module prio_regfile #(
  parameter int          NUM_SOURCES    = 8,
  parameter int          NUM_CONTEXTS   = 2,
  parameter int          MAX_PRIO       = 7,
  parameter logic [31:0] PRIORITY_BASE  = 32'h0000_0004,
  parameter logic [31:0] PENDING_BASE   = 32'h0000_1000,
  parameter logic [31:0] CONTEXT_BASE   = 32'h0000_2000,
  parameter logic [31:0] CONTEXT_STRIDE = 32'h0000_1000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_valid,
  input  logic                    bus_write,
  input  logic [31:0]             bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    bus_err,
  input  logic [NUM_SOURCES:0]    pending,
  output logic [NUM_CONTEXTS-1:0] irq
);
  localparam int PW         = (MAX_PRIO < 2) ? 1 : $clog2(MAX_PRIO + 1);
  localparam bit WRAP       = ((MAX_PRIO + 1) & MAX_PRIO) == 0;
  localparam int PEND_WORDS = (NUM_SOURCES + 32) / 32;
  localparam logic [31:0] PRIO_END = PRIORITY_BASE + 32'(4 * NUM_SOURCES);
  localparam logic [31:0] PEND_END = PENDING_BASE + 32'(4 * PEND_WORDS);
  localparam logic [31:0] CTX_END  = CONTEXT_BASE + 32'(NUM_CONTEXTS) * CONTEXT_STRIDE;

  logic [PW-1:0] prio_q [NUM_SOURCES];
  logic [PW-1:0] thr_q  [NUM_CONTEXTS];
  logic [PEND_WORDS*32-1:0] pend_pad;
  logic [31:0] prio_off, pend_off, ctx_off, ctx_idx, ctx_in, rd_val;
  logic hit_prio, hit_pend, hit_thr, legal, wr_ok;
  logic [PW-1:0] wval;

  assign pend_pad = (PEND_WORDS*32)'(pending);
  assign prio_off = (bus_addr - PRIORITY_BASE) >> 2;
  assign pend_off = (bus_addr - PENDING_BASE) >> 2;
  assign ctx_off  = bus_addr - CONTEXT_BASE;
  assign ctx_idx  = ctx_off / CONTEXT_STRIDE;
  assign ctx_in   = ctx_off % CONTEXT_STRIDE;

  assign hit_prio = bus_addr >= PRIORITY_BASE && bus_addr < PRIO_END;
  assign hit_pend = bus_addr >= PENDING_BASE && bus_addr < PEND_END;
  assign hit_thr  = bus_addr >= CONTEXT_BASE && bus_addr < CTX_END && ctx_in == 32'd0;

  assign legal = WRAP || (bus_wdata <= 32'(MAX_PRIO));
  assign wval  = bus_wdata[PW-1:0];
  assign wr_ok = bus_valid && bus_write && legal;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SOURCES; i++) begin
      if (rst) prio_q[i] <= '0;
      else if (wr_ok && hit_prio && prio_off == 32'(i)) prio_q[i] <= wval;
    end
    for (int c = 0; c < NUM_CONTEXTS; c++) begin
      if (rst) thr_q[c] <= '0;
      else if (wr_ok && hit_thr && ctx_idx == 32'(c)) thr_q[c] <= wval;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_SOURCES; i++)
      if (hit_prio && prio_off == 32'(i)) rd_val = 32'(prio_q[i]);
    for (int c = 0; c < NUM_CONTEXTS; c++)
      if (hit_thr && ctx_idx == 32'(c)) rd_val = 32'(thr_q[c]);
    for (int w = 0; w < PEND_WORDS; w++)
      if (hit_pend && pend_off == 32'(w)) rd_val = pend_pad[w*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= (bus_valid && !bus_write) ? rd_val : '0;
      bus_err   <= bus_valid && bus_write && hit_pend;
    end
  end

  for (genvar c = 0; c < NUM_CONTEXTS; c++) begin : g_ctx
    always_comb begin
      irq[c] = 1'b0;
      for (int n = 1; n <= NUM_SOURCES; n++)
        if (pending[n] && prio_q[n-1] > thr_q[c]) irq[c] = 1'b1;
    end
  end
endmodule

// File: rtl/prio_regfile_chk.sv
module prio_regfile_chk #(
  parameter int          NUM_SOURCES    = 8,
  parameter int          NUM_CONTEXTS   = 2,
  parameter int          MAX_PRIO       = 7,
  parameter logic [31:0] PRIORITY_BASE  = 32'h0000_0004,
  parameter logic [31:0] PENDING_BASE   = 32'h0000_1000,
  parameter logic [31:0] CONTEXT_BASE   = 32'h0000_2000,
  parameter logic [31:0] CONTEXT_STRIDE = 32'h0000_1000
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [31:0]             bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic                    bus_err,
  input logic [NUM_SOURCES:0]    pending,
  input logic [NUM_CONTEXTS-1:0] irq
);
  localparam bit WRAP = ((MAX_PRIO + 1) & MAX_PRIO) == 0;
  localparam int PEND_WORDS = (NUM_SOURCES + 32) / 32;
  logic in_prio, in_pend, in_thr, is_rd, is_wr;
  logic [31:0] coff;

  assign coff    = bus_addr - CONTEXT_BASE;
  assign in_prio = bus_addr >= PRIORITY_BASE && bus_addr < PRIORITY_BASE + 32'(4*NUM_SOURCES);
  assign in_pend = bus_addr >= PENDING_BASE && bus_addr < PENDING_BASE + 32'(4*PEND_WORDS);
  assign in_thr  = bus_addr >= CONTEXT_BASE
                && bus_addr < CONTEXT_BASE + 32'(NUM_CONTEXTS) * CONTEXT_STRIDE
                && (coff % CONTEXT_STRIDE) == 32'd0;
  assign is_rd = bus_valid && !bus_write;
  assign is_wr = bus_valid && bus_write;

  assert_pend_write_err_R5: assert property (@(posedge clk) disable iff (rst)
    (is_wr && in_pend) |=> bus_err);
  assert_no_other_err_R8: assert property (@(posedge clk) disable iff (rst)
    !(is_wr && in_pend) |=> !bus_err);
  assert_prio_read_legal_R1: assert property (@(posedge clk) disable iff (rst)
    (is_rd && (in_prio || in_thr)) |=> bus_rdata <= 32'(MAX_PRIO));
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (is_rd && !in_prio && !in_pend && !in_thr) |=> bus_rdata == 32'd0);
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> bus_rdata == 32'd0);
  assert_reject_keeps_irq_R3: assert property (@(posedge clk) disable iff (rst)
    (!WRAP && is_wr && (in_prio || in_thr) && bus_wdata > 32'(MAX_PRIO))
      |=> ($stable(pending) -> $stable(irq)));
endmodule

bind prio_regfile prio_regfile_chk #(
  .NUM_SOURCES(NUM_SOURCES), .NUM_CONTEXTS(NUM_CONTEXTS), .MAX_PRIO(MAX_PRIO),
  .PRIORITY_BASE(PRIORITY_BASE), .PENDING_BASE(PENDING_BASE),
  .CONTEXT_BASE(CONTEXT_BASE), .CONTEXT_STRIDE(CONTEXT_STRIDE)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .pending(pending), .irq(irq)
);

// File: tb/prio_regfile_bench.sv
module prio_regfile_bench;
  localparam int PERIOD = 10;
  localparam logic [31:0] PB = 32'h4, PNB = 32'h1000, CB = 32'h2000, CS = 32'h1000;

  logic clk = 1'b0, rst = 1'b1, bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [8:0] pending = '0;
  logic [31:0] rdata_a, rdata_b;
  logic err_a, err_b;
  logic [1:0] irq_a, irq_b;
  logic [31:0] ra, rb;
  logic ea, eb;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  prio_regfile #(.MAX_PRIO(7)) u_prio_regfile (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .bus_err(err_a), .pending(pending), .irq(irq_a));

  prio_regfile #(.MAX_PRIO(5)) u_prio_regfile_rej (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .bus_err(err_b), .pending(pending), .irq(irq_b));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pending = '0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); ea = err_a; eb = err_b; bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk); ra = rdata_a; rb = rdata_b; bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R9 irq a", 32'(irq_a), 0); chk("R9 irq b", 32'(irq_b), 0);
    chk("R9 err", 32'(err_a | err_b), 0); chk("R9 rdata", rdata_a, 0);
    rd(PB); chk("R9 prio1 a", ra, 0);
    rd(CB); chk("R9 thr0 b", rb, 0);
  endtask

  task automatic t_prio_addr();
    do_reset();
    wr(PB, 2); wr(PB + 28, 6 - 1);
    rd(PB);      chk("R1 src1 a", ra, 2); chk("R1 src1 b", rb, 2);
    rd(PB + 28); chk("R1 src8 a", ra, 5); chk("R1 src8 b", rb, 5);
    rd(PB + 4);  chk("R1 src2 untouched", ra, 0);
    @(negedge clk); chk("R10 idle rdata", rdata_a, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(PB, 32'h1D);        rd(PB); chk("R2 mod 29", ra, 5);
    wr(PB, 32'hFFFF_FFF9); rd(PB); chk("R2 mod big", ra, 1);
  endtask

  task automatic t_reject();
    do_reset();
    wr(PB, 3);     rd(PB); chk("R3 in range", rb, 3);
    wr(PB, 32'h1D); rd(PB); chk("R3 reject 29", rb, 3);
    wr(PB, 5);     rd(PB); chk("R3 max", rb, 5);
    wr(PB, 6);     rd(PB); chk("R3 reject 6", rb, 5);
  endtask

  task automatic t_thr();
    do_reset();
    wr(CB + CS, 32'h0C);
    rd(CB + CS); chk("R4 thr1 wrap a", ra, 4); chk("R4 thr1 reject b", rb, 0);
    rd(CB);      chk("R4 thr0 untouched", ra, 0);
    wr(CB + CS, 2); wr(CB + CS, 7);
    rd(CB + CS); chk("R4 thr1 a", ra, 7); chk("R4 thr1 b", rb, 2);
  endtask

  task automatic t_pend();
    do_reset();
    wr(PB, 2);
    pending = 9'h106;
    rd(PNB); chk("R5 pend read a", ra, 32'h106); chk("R5 pend read b", rb, 32'h106);
    wr(PNB, 32'hFFFF);
    chk("R5 err a", 32'(ea), 1); chk("R5 err b", 32'(eb), 1);
    rd(PB); chk("R5 prio kept", ra, 2);
    rd(PNB); chk("R5 pend unchanged", ra, 32'h106);
  endtask

  task automatic t_irq();
    do_reset();
    pending = 9'h001;
    wr(PB + 4, 4);
    chk("R6 bit0 ignored", 32'(irq_a), 0);
    @(negedge clk); pending = 9'h004; #1;
    chk("R6 both a", 32'(irq_a), 3); chk("R6 both b", 32'(irq_b), 3);
    wr(CB + CS, 4);
    chk("R6 thr1 equal", 32'(irq_a), 1); chk("R6 thr1 equal b", 32'(irq_b), 1);
    wr(CB, 5);
    chk("R6 thr0 above", 32'(irq_a), 0); chk("R6 thr0 above b", 32'(irq_b), 0);
  endtask

  task automatic t_zero();
    do_reset();
    @(negedge clk); pending = 9'h1FE; #1;
    chk("R7 zero prio a", 32'(irq_a), 0); chk("R7 zero prio b", 32'(irq_b), 0);
    wr(PB + 8, 1);
    chk("R7 prio1 raises", 32'(irq_a), 3);
  endtask

  task automatic t_unmapped();
    do_reset();
    rd(32'h0800); chk("R8 gap read", ra, 0);
    rd(32'h0000); chk("R8 below base", ra, 0);
    wr(CB + 4, 7);
    chk("R8 no err a", 32'(ea), 0); chk("R8 no err b", 32'(eb), 0);
    rd(CB + 4); chk("R8 ctx offset read", ra, 0);
    rd(CB);     chk("R8 thr0 untouched", ra, 0);
    wr(PB, 3);  chk("R8 no err prio write", 32'(ea), 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset(); t_prio_addr(); t_wrap(); t_reject(); t_thr();
    t_pend(); t_irq(); t_zero(); t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule